// File: doc/BRIEF.md
# Two-Floor Freight Lift Controller

This block is the sequencing core of a small lift that moves loads between a lower and an upper floor. It samples four call buttons, one limit switch per floor and a clear input on every rising clock edge. From these it drives a motor inhibit line, a travel direction line, and a green and a red indicator per floor. It is a four-position Moore machine: parked low, rising, parked high and descending. After power-up or a clear it always descends until the lower limit switch closes. The debouncing of the inputs, the motor phase drive and the clock source are handled outside.

A one-clock pulse marks the end of each round trip, defined as reaching the lower floor after having left the upper one, so a counter placed beside the block can track usage. When the `DOOR_EN` parameter is set, a door interlock is built in. The car leaves a floor only while both door-closed sensors read 1, and each floor's door lock is released only while the car is parked at that floor. The `ENC` parameter selects how the position register is encoded (binary, Gray, Johnson or one-hot) and does not change the behaviour seen at the ports.

Top module: `lift2_ctrl`

## Requirements
- R1: A synchronous `rst_i` or `cd_i` at a clock edge puts the car into descent: `inh_o`=0, `dir_up_o`=0, `red_o`=2'b11, `grn_o`=2'b00, `cycle_done_o`=0.
- R2: While descending, `ls_i[0]`=1 at an edge parks the car low: `inh_o`=1, `dir_up_o`=0, `grn_o`=2'b01, `red_o`=2'b00.
- R3: Parked low, a call on `call_i[0]` (up, floor 0) or `call_i[2]` (up, floor 1) starts the rise if departure is allowed: `inh_o`=0, `dir_up_o`=1, `red_o`=2'b11.
- R4: While rising, `ls_i[1]`=1 at an edge parks the car high: `inh_o`=1, `grn_o`=2'b10, `red_o`=2'b00.
- R5: Parked high, a call on `call_i[1]` (down, floor 0) or `call_i[3]` (down, floor 1) starts the descent if departure is allowed.
- R6: Calls that would not move the car are ignored: down calls while parked low, up calls while parked high, and every call while travelling. Limit switches are ignored while parked.
- R7: `cycle_done_o` pulses high for exactly one cycle, in the cycle the car parks low after a descent that started from the upper floor. A descent caused by reset or clear gives no pulse.
- R8: With `DOOR_EN`=1, the car does not leave a floor unless `door_closed_i`=2'b11 at that edge.
- R9: With `DOOR_EN`=1, `door_lock_o[f]`=0 only while the car is parked at floor f. The lock is 1 in every other state, including all travel.
- R10: With `DOOR_EN`=0, `door_closed_i` has no effect and `door_lock_o` stays 2'b00.
- R11: All four values of `ENC` (0 binary, 1 Gray, 2 Johnson, 3 one-hot) give identical port behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset (power-up homing) |
| cd_i | input | 1 | Synchronous clear; sends the car home to the lower floor |
| call_i | input | 4 | Call buttons: [0] up@0, [1] down@0, [2] up@1, [3] down@1 |
| ls_i | input | 2 | Limit switches: [0] car at floor 0, [1] car at floor 1 |
| door_closed_i | input | 2 | Door-closed sensors per floor (used when DOOR_EN=1) |
| inh_o | output | 1 | Motor inhibit; 1 stops the motor |
| dir_up_o | output | 1 | Direction when not inhibited: 1 up, 0 down |
| grn_o | output | 2 | Green indicator per floor, on while parked there |
| red_o | output | 2 | Red indicators, on while travelling |
| door_lock_o | output | 2 | Door lock per floor, 1 = locked |
| cycle_done_o | output | 1 | One-cycle pulse at the end of a round trip |

## Verification
Each of the four positions is reached by a fixed route, including a descent entered by clearing and one entered from the upper floor. From each of these starting points, every combination of the four call buttons, the three legal limit-switch patterns and the four door-sensor patterns is applied for one cycle. This shows which calls depart and which are ignored, whether arrival depends on the correct switch, whether departure waits for the doors, and whether the round-trip pulse comes only after a true upper-floor departure. All four encodings and a build without the interlock receive the same stimulus. Their outputs are compared with a model in the bench and with each other.

// File: rtl/lift2_pkg.sv
package lift2_pkg;

  typedef enum logic [1:0] {
    POS_AT0  = 2'd0,
    POS_UP   = 2'd1,
    POS_AT1  = 2'd2,
    POS_DOWN = 2'd3
  } pos_e;

  localparam int ENC_BIN    = 0;
  localparam int ENC_GRAY   = 1;
  localparam int ENC_JOHN   = 2;
  localparam int ENC_ONEHOT = 3;

  function automatic int code_bits(int enc);
    return (enc == ENC_ONEHOT) ? 4 : 2;
  endfunction

  function automatic logic [3:0] pos_encode(int enc, pos_e p);
    logic [1:0] i;
    i = p;
    case (enc)
      ENC_GRAY:   return {2'b00, i ^ {1'b0, i[1]}};
      ENC_JOHN: begin
        case (i)
          2'd0:    return 4'b0000;
          2'd1:    return 4'b0001;
          2'd2:    return 4'b0011;
          default: return 4'b0010;
        endcase
      end
      ENC_ONEHOT: return 4'b0001 << i;
      default:    return {2'b00, i};
    endcase
  endfunction

  function automatic pos_e pos_decode(int enc, logic [3:0] c);
    for (int k = 0; k < 4; k++) begin
      if (c == pos_encode(enc, pos_e'(k[1:0]))) return pos_e'(k[1:0]);
    end
    return POS_DOWN;
  endfunction

endpackage

// File: rtl/lift2_next.sv
module lift2_next
  import lift2_pkg::*;
#(
  parameter int DOOR_EN = 1
) (
  input  pos_e       cur_i,
  input  logic [3:0] call_i,
  input  logic [1:0] ls_i,
  input  logic [1:0] door_closed_i,
  output pos_e       nxt_o
);
  logic doors_ok;

  generate
    if (DOOR_EN != 0) begin : g_interlock
      assign doors_ok = &door_closed_i;
    end else begin : g_free
      assign doors_ok = 1'b1;
    end
  endgenerate

  always_comb begin
    nxt_o = cur_i;
    case (cur_i)
      POS_AT0:  if ((call_i[0] | call_i[2]) && doors_ok) nxt_o = POS_UP;
      POS_UP:   if (ls_i[1]) nxt_o = POS_AT1;
      POS_AT1:  if ((call_i[1] | call_i[3]) && doors_ok) nxt_o = POS_DOWN;
      default:  if (ls_i[0]) nxt_o = POS_AT0;
    endcase
  end
endmodule

// File: rtl/lift2_state_reg.sv
module lift2_state_reg
  import lift2_pkg::*;
#(
  parameter int ENC = ENC_BIN
) (
  input  logic clk_i,
  input  logic clr_i,
  input  pos_e nxt_i,
  output pos_e cur_o
);
  localparam int W = code_bits(ENC);

  logic [W-1:0] q;
  logic [3:0]   nxt_code;
  logic [3:0]   home_code;
  logic [3:0]   q_ext;

  always_comb begin
    nxt_code  = pos_encode(ENC, nxt_i);
    home_code = pos_encode(ENC, POS_DOWN);
    q_ext     = '0;
    q_ext[W-1:0] = q;
  end

  always_ff @(posedge clk_i) begin
    if (clr_i) q <= home_code[W-1:0];
    else       q <= nxt_code[W-1:0];
  end

  assign cur_o = pos_decode(ENC, q_ext);

  // R11: the register only ever holds one of the four legal codes
  p_code_legal_r11: assert property (@(posedge clk_i) disable iff (clr_i)
    pos_encode(ENC, cur_o) == q_ext);
endmodule

// File: rtl/lift2_outreg.sv
module lift2_outreg
  import lift2_pkg::*;
#(
  parameter int DOOR_EN = 1
) (
  input  logic       clk_i,
  input  logic       clr_i,
  input  pos_e       nxt_i,
  input  logic       trip_end_i,
  output logic       inh_o,
  output logic       dir_up_o,
  output logic [1:0] grn_o,
  output logic [1:0] red_o,
  output logic [1:0] lock_o,
  output logic       cycle_done_o
);
  pos_e tgt;
  logic moving;

  assign tgt    = clr_i ? POS_DOWN : nxt_i;
  assign moving = (tgt == POS_UP) || (tgt == POS_DOWN);

  always_ff @(posedge clk_i) begin
    inh_o        <= !moving;
    dir_up_o     <= (tgt == POS_UP);
    grn_o        <= {tgt == POS_AT1, tgt == POS_AT0};
    red_o        <= {2{moving}};
    cycle_done_o <= trip_end_i && !clr_i;
  end

  generate
    if (DOOR_EN != 0) begin : g_locks
      always_ff @(posedge clk_i) begin
        lock_o <= {tgt != POS_AT1, tgt != POS_AT0};
      end
    end else begin : g_nolocks
      assign lock_o = 2'b00;
    end
  endgenerate

  // R2/R4: a parked indicator is never lit together with a travel indicator
  p_grn_red_excl_r2: assert property (@(posedge clk_i) disable iff (clr_i)
    !((|grn_o) && (|red_o)));
endmodule

// File: rtl/lift2_ctrl.sv
module lift2_ctrl
  import lift2_pkg::*;
#(
  parameter int ENC     = ENC_BIN,
  parameter int DOOR_EN = 1
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       cd_i,
  input  logic [3:0] call_i,
  input  logic [1:0] ls_i,
  input  logic [1:0] door_closed_i,
  output logic       inh_o,
  output logic       dir_up_o,
  output logic [1:0] grn_o,
  output logic [1:0] red_o,
  output logic [1:0] door_lock_o,
  output logic       cycle_done_o
);
  logic clr;
  pos_e cur;
  pos_e nxt;
  logic from_top;
  logic trip_end;

  assign clr = rst_i | cd_i;

  lift2_next #(.DOOR_EN(DOOR_EN)) next_i (
    .cur_i(cur), .call_i(call_i), .ls_i(ls_i),
    .door_closed_i(door_closed_i), .nxt_o(nxt)
  );

  lift2_state_reg #(.ENC(ENC)) state_i (
    .clk_i(clk_i), .clr_i(clr), .nxt_i(nxt), .cur_o(cur)
  );

  // descent started at the upper floor (not a homing descent)
  always_ff @(posedge clk_i) begin
    if (clr)                                       from_top <= 1'b0;
    else if (cur == POS_AT1 && nxt == POS_DOWN)    from_top <= 1'b1;
    else if (cur == POS_DOWN && nxt == POS_AT0)    from_top <= 1'b0;
  end

  assign trip_end = (cur == POS_DOWN) && (nxt == POS_AT0) && from_top;

  lift2_outreg #(.DOOR_EN(DOOR_EN)) out_i (
    .clk_i(clk_i), .clr_i(clr), .nxt_i(nxt), .trip_end_i(trip_end),
    .inh_o(inh_o), .dir_up_o(dir_up_o), .grn_o(grn_o), .red_o(red_o),
    .lock_o(door_lock_o), .cycle_done_o(cycle_done_o)
  );

  // R7: round-trip pulse lasts one cycle
  p_pulse_single_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    cycle_done_o |=> !cycle_done_o);

  // R6: calls during a rise do not disturb it
  p_transit_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (cur == POS_UP && !ls_i[1] && !cd_i) |=> (cur == POS_UP));

  // R8: motor released from a floor only with both doors closed
  p_doors_before_move_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (DOOR_EN != 0 && $fell(inh_o) && !$past(cd_i)) |-> ($past(door_closed_i) == 2'b11));

  // R9: every door locked while the motor runs
  p_lock_moving_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (DOOR_EN != 0 && !inh_o) |-> (door_lock_o == 2'b11));
endmodule

// File: tb/lift2_ctrl_tb.sv
module lift2_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NDUT = 5;

  logic       clk = 1'b0;
  logic       rst;
  logic       cd;
  logic [3:0] call;
  logic [1:0] ls;
  logic [1:0] dc;

  logic [6:0] obs [NDUT];
  logic [1:0] lck [NDUT];

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  // model state: index 0 = interlocked builds, 1 = build without interlock
  int m_st [2];
  bit m_flag [2];
  bit m_cyc [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  lift2_ctrl #(.ENC(0), .DOOR_EN(1)) dut_i (
    .clk_i(clk), .rst_i(rst), .cd_i(cd), .call_i(call), .ls_i(ls),
    .door_closed_i(dc), .inh_o(obs[0][0]), .dir_up_o(obs[0][1]),
    .grn_o(obs[0][3:2]), .red_o(obs[0][5:4]), .door_lock_o(lck[0]),
    .cycle_done_o(obs[0][6])
  );

  for (genvar k = 1; k < 4; k++) begin : g_enc
    lift2_ctrl #(.ENC(k), .DOOR_EN(1)) dut_enc (
      .clk_i(clk), .rst_i(rst), .cd_i(cd), .call_i(call), .ls_i(ls),
      .door_closed_i(dc), .inh_o(obs[k][0]), .dir_up_o(obs[k][1]),
      .grn_o(obs[k][3:2]), .red_o(obs[k][5:4]), .door_lock_o(lck[k]),
      .cycle_done_o(obs[k][6])
    );
  end

  lift2_ctrl #(.ENC(3), .DOOR_EN(0)) dut_nodoor (
    .clk_i(clk), .rst_i(rst), .cd_i(cd), .call_i(call), .ls_i(ls),
    .door_closed_i(dc), .inh_o(obs[4][0]), .dir_up_o(obs[4][1]),
    .grn_o(obs[4][3:2]), .red_o(obs[4][5:4]), .door_lock_o(lck[4]),
    .cycle_done_o(obs[4][6])
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // {cycle, red[1:0], grn[1:0], up, inh}; st 0 low,1 rising,2 high,3 descending
  function automatic logic [6:0] exp_vec(int st, bit cyc);
    bit mv;
    mv = (st == 1) || (st == 3);
    return {cyc, {2{mv}}, st == 2, st == 0, st == 1, !mv};
  endfunction

  function automatic logic [1:0] exp_lock(int st, bit den);
    if (!den) return 2'b00;
    return {st != 2, st != 0};
  endfunction

  function automatic string pick_tag(int st, bit flag, bit c, logic [3:0] cl,
                                     logic [1:0] l, logic [1:0] d, bit den);
    if (c) return "R1";
    if (st == 3 && l[0]) return flag ? "R7" : "R2";
    if (st == 1 && l[1]) return "R4";
    if (st == 1 || st == 3) return "R6";
    if (st == 0 && !(cl[0] | cl[2])) return "R6";
    if (st == 2 && !(cl[1] | cl[3])) return "R6";
    if (d != 2'b11) return den ? "R8" : "R10";
    return (st == 0) ? "R3" : "R5";
  endfunction

  task automatic model_step(input int m, input bit c, input logic [3:0] cl,
                            input logic [1:0] l, input logic [1:0] d);
    bit ok;
    ok = (m == 1) || (d == 2'b11);
    m_cyc[m] = 1'b0;
    if (c) begin
      m_st[m] = 3; m_flag[m] = 1'b0;
    end else begin
      case (m_st[m])
        0: if ((cl[0] | cl[2]) && ok) m_st[m] = 1;
        1: if (l[1]) m_st[m] = 2;
        2: if ((cl[1] | cl[3]) && ok) begin m_st[m] = 3; m_flag[m] = 1'b1; end
        default: if (l[0]) begin
          m_cyc[m] = m_flag[m]; m_flag[m] = 1'b0; m_st[m] = 0;
        end
      endcase
    end
  endtask

  task automatic apply(input bit c, input logic [3:0] cl, input logic [1:0] l,
                       input logic [1:0] d);
    string tg [2];
    for (int m = 0; m < 2; m++)
      tg[m] = pick_tag(m_st[m], m_flag[m], c, cl, l, d, m == 0);
    cd = c; call = cl; ls = l; dc = d;
    @(posedge clk); #1;
    for (int m = 0; m < 2; m++) model_step(m, c, cl, l, d);
    for (int k = 0; k < NDUT; k++) begin
      int m;
      m = (k == 4) ? 1 : 0;
      chk(obs[k] == exp_vec(m_st[m], m_cyc[m]), tg[m], obs[k], exp_vec(m_st[m], m_cyc[m]));
      chk(lck[k] == exp_lock(m_st[m], m == 0), (m == 0) ? "R9" : "R10",
          lck[k], exp_lock(m_st[m], m == 0));
    end
    for (int k = 1; k < 4; k++)
      chk(obs[k] == obs[0] && lck[k] == lck[0], "R11", {lck[k], obs[k]}, {lck[0], obs[0]});
  endtask

  // start: 0 low, 1 rising, 2 high, 3 descending from top, 4 homing descent
  task automatic goto_pos(input int start);
    apply(1'b1, 4'b0000, 2'b00, 2'b11);
    if (start == 4) return;
    apply(1'b0, 4'b0000, 2'b01, 2'b11);
    if (start == 0) return;
    apply(1'b0, 4'b0001, 2'b00, 2'b11);
    if (start == 1) return;
    apply(1'b0, 4'b0000, 2'b10, 2'b11);
    if (start == 2) return;
    apply(1'b0, 4'b1000, 2'b00, 2'b11);
  endtask

  initial begin
    rst = 1'b1; cd = 1'b0; call = '0; ls = '0; dc = 2'b11;
    for (int m = 0; m < 2; m++) begin m_st[m] = 3; m_flag[m] = 1'b0; m_cyc[m] = 1'b0; end
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state is a homing descent
    for (int k = 0; k < NDUT; k++)
      chk(obs[k] == exp_vec(3, 1'b0), "R1", obs[k], exp_vec(3, 1'b0));
    rst = 1'b0;
    // full round trip ends with a pulse (R7), then clear mid-high (R1)
    goto_pos(3);
    apply(1'b0, 4'b0000, 2'b01, 2'b11);
    goto_pos(2);
    apply(1'b1, 4'b1111, 2'b10, 2'b00);
    apply(1'b0, 4'b0000, 2'b01, 2'b11);
    // near-exhaustive sweep: start position x calls x switches x doors
    for (int s = 0; s < 5; s++) begin
      for (int cmb = 0; cmb < 192; cmb++) begin
        logic [1:0] lv;
        int li;
        li = (cmb >> 4) % 3;
        lv = (li == 0) ? 2'b00 : (li == 1) ? 2'b01 : 2'b10;
        goto_pos(s);
        apply(1'b0, cmb[3:0], lv, 2'((cmb / 48) % 4));
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule